// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block arbitrates among a set of peripheral interrupt sources for a single processor core. Each source owns a small control word made of a pending flag and a three-bit priority level. A peripheral event pulse sets the pending flag whatever the level or the core's global enable. The controller compares every pending source against the core's global enable flag and its current running level. It raises a request whenever at least one source may interrupt.

When the core acknowledges, the controller does several things in one cycle. It latches the winning source number and level, clears that source's pending flag and saves the global enable and running level. It then clears the global enable and raises the running level to the winner's level. A return strobe from the core puts back the saved enable and level.

Software can reprogram a source's level and can clear its pending flag, but it can never set the flag. Service is one level deep: while a routine is being serviced no further request is offered.

The core sequencer has two states. `ST_IDLE` means no routine is active, and `ST_SERVE` means a routine is active. There are two transitions. `TAKE` goes from `ST_IDLE` to `ST_SERVE` when an acknowledge arrives while a request is shown. `RETURN` goes from `ST_SERVE` to `ST_IDLE` when the return strobe arrives. Any other input leaves the state unchanged.

Top module: `prio_intc`

## Requirements
- R1: After reset every pending flag and every level is 0, the global enable is 0, the running level is 0, the sequencer is in ST_IDLE, `irq_req_o` is 0 and `irq_num_o`/`irq_lvl_o` are 0.
- R2: An event pulse on `evt_i[k]` sets source k's pending flag at the next clock edge, regardless of its level, the global enable or the sequencer state.
- R3: `irq_req_o` is 1 exactly when the sequencer is in ST_IDLE, the global enable is 1, and some source has its pending flag set and a level strictly greater than the running level. A source with level 0 therefore never requests.
- R4: The winner is the eligible source with the highest level. Among eligible sources of equal level, the lowest index wins.
- R5: On TAKE (`ack_i`=1 while `irq_req_o`=1) the next cycle shows the following. `irq_num_o`/`irq_lvl_o` give the winner. The winner's pending flag is cleared unless a new event for it arrived in the same cycle. The global enable is 0, the running level equals the winner's level, and the state is ST_SERVE.
- R6: `irq_num_o` and `irq_lvl_o` change only at a TAKE and hold their value otherwise.
- R7: On RETURN (`ret_i`=1 in ST_SERVE) the global enable and running level take back the values they had just before the matching TAKE, and the state goes to ST_IDLE. `ret_i` in ST_IDLE and `ack_i` without a request have no effect. In ST_IDLE the running level is always 0.
- R8: An event for a source during its own service sets its flag again, so the source requests again right after RETURN.
- R9: A software write (`sw_wr_i`) to source `sw_idx_i` loads its level from `sw_wdata_i[2:0]`. It clears its pending flag when `sw_wdata_i[3]`=0 and leaves the flag unchanged when `sw_wdata_i[3]`=1; a write never sets the flag. An event in the same cycle as a clearing write leaves the flag set. `sw_rdata_o` gives {flag, level} as bits [3] and [2:0] of source `sw_rd_idx_i`, combinationally.
- R10: `gie_wr_i` loads the global enable from `gie_i`. A TAKE or RETURN in the same cycle takes precedence over this write.
- R11: In ST_SERVE `irq_req_o` stays 0 and `ack_i` is ignored, even if software sets the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Per-source event pulses |
| sw_wr_i | input | 1 | Software write strobe for a control word |
| sw_idx_i | input | IDX_W | Source written by software |
| sw_wdata_i | input | 4 | Bit 3 keep flag (0 clears), bits 2:0 level |
| sw_rd_idx_i | input | IDX_W | Source read by software |
| sw_rdata_o | output | 4 | {pending flag, level} of the read source |
| gie_wr_i | input | 1 | Global enable write strobe |
| gie_i | input | 1 | Global enable value to write |
| ack_i | input | 1 | Core acknowledge |
| ret_i | input | 1 | Core return-from-service strobe |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_num_o | output | IDX_W | Number of the last accepted source |
| irq_lvl_o | output | 3 | Level of the last accepted source |
| gie_o | output | 1 | Global enable flag |
| cur_lvl_o | output | 3 | Current running level |

## Verification
The assertions make no assumption about when the core may drive `ack_i` or `ret_i`. Strobes that arrive outside their proper state must be absorbed by the block itself, and the stimulus drives both freely, including acknowledges with no request and returns while idle. The no-software-set property assumes that any rise of a pending flag is caused by an event pulse one cycle earlier. The stimulus therefore issues writes with the keep bit both set and clear against flags in either state, and some of these writes fall in the same cycle as events. Levels are rewritten at random, including during service, so that ties, zero levels and equal running levels all occur.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    localparam int LVL_W      = 3;
    localparam int CTL_W      = LVL_W + 1;
    localparam int KEEP_BIT   = LVL_W;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic             found;
        logic [LVL_W-1:0] lvl;
    } win_info_t;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            evt_i,
    input  logic                          take_i,
    input  logic [IDX_W-1:0]              take_idx_i,
    input  logic                          sw_wr_i,
    input  logic [IDX_W-1:0]              sw_idx_i,
    input  logic [CTL_W-1:0]              sw_wdata_i,
    input  logic [IDX_W-1:0]              sw_rd_idx_i,
    output logic [CTL_W-1:0]              sw_rdata_o,
    output logic [NUM_SRC-1:0]            pend_o,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_o
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic sel_sw;
        logic sel_take;
        assign sel_sw   = sw_wr_i && (sw_idx_i == IDX_W'(g));
        assign sel_take = take_i && (take_idx_i == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_o[g] <= 1'b0;
                lvl_o[g]  <= '0;
            end else begin
                // an event always wins over any clearing source
                if (evt_i[g])
                    pend_o[g] <= 1'b1;
                else if (sel_take || (sel_sw && !sw_wdata_i[KEEP_BIT]))
                    pend_o[g] <= 1'b0;
                if (sel_sw)
                    lvl_o[g] <= sw_wdata_i[LVL_W-1:0];
            end
        end
    end

    assign sw_rdata_o = {pend_o[sw_rd_idx_i], lvl_o[sw_rd_idx_i]};
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            pend_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0]              cur_lvl_i,
    output win_info_t                     win_o,
    output logic [IDX_W-1:0]              win_idx_o
);
    always_comb begin
        win_o     = '0;
        win_idx_o = '0;
        // strict compare keeps the lowest index on a tie
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i] && (lvl_i[i] > cur_lvl_i) &&
                (!win_o.found || (lvl_i[i] > win_o.lvl))) begin
                win_o.found = 1'b1;
                win_o.lvl   = lvl_i[i];
                win_idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_core_fsm.sv
module intc_core_fsm
    import prio_intc_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  win_info_t        win_i,
    input  logic [IDX_W-1:0] win_idx_i,
    input  logic             ack_i,
    input  logic             ret_i,
    input  logic             gie_wr_i,
    input  logic             gie_i,
    output logic             req_o,
    output logic             take_o,
    output logic [IDX_W-1:0] num_o,
    output logic [LVL_W-1:0] lvl_o,
    output logic             gie_o,
    output logic [LVL_W-1:0] cur_lvl_o,
    output logic             in_svc_o
);
    seq_state_t       state_q, state_d;
    logic             ret_take;
    logic             saved_gie;
    logic [LVL_W-1:0] saved_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take_o)   state_d = ST_SERVE;  // TAKE
            ST_SERVE: if (ret_take) state_d = ST_IDLE;   // RETURN
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_o    = 1'b0;
        ret_take = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_o    = gie_o && win_i.found;
            ST_SERVE: ret_take = ret_i;
            default:  req_o    = 1'b0;
        endcase
        take_o   = req_o && ack_i;
        in_svc_o = (state_q == ST_SERVE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_o     <= 1'b0;
            cur_lvl_o <= '0;
            saved_gie <= 1'b0;
            saved_lvl <= '0;
            num_o     <= '0;
            lvl_o     <= '0;
        end else if (take_o) begin
            saved_gie <= gie_o;
            saved_lvl <= cur_lvl_o;
            gie_o     <= 1'b0;
            cur_lvl_o <= win_i.lvl;
            num_o     <= win_idx_i;
            lvl_o     <= win_i.lvl;
        end else if (ret_take) begin
            gie_o     <= saved_gie;
            cur_lvl_o <= saved_lvl;
        end else if (gie_wr_i) begin
            gie_o     <= gie_i;
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               sw_wr_i,
    input  logic [IDX_W-1:0]   sw_idx_i,
    input  logic [CTL_W-1:0]   sw_wdata_i,
    input  logic [IDX_W-1:0]   sw_rd_idx_i,
    output logic [CTL_W-1:0]   sw_rdata_o,
    input  logic               gie_wr_i,
    input  logic               gie_i,
    input  logic               ack_i,
    input  logic               ret_i,
    output logic               irq_req_o,
    output logic [IDX_W-1:0]   irq_num_o,
    output logic [LVL_W-1:0]   irq_lvl_o,
    output logic               gie_o,
    output logic [LVL_W-1:0]   cur_lvl_o
);
    logic [NUM_SRC-1:0]            ir_vec;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl_vec;
    win_info_t                     win;
    logic [IDX_W-1:0]              win_idx;
    logic                          take;
    logic                          in_svc;

    intc_src_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .take_i(take), .take_idx_i(win_idx),
        .sw_wr_i(sw_wr_i), .sw_idx_i(sw_idx_i), .sw_wdata_i(sw_wdata_i),
        .sw_rd_idx_i(sw_rd_idx_i), .sw_rdata_o(sw_rdata_o),
        .pend_o(ir_vec), .lvl_o(lvl_vec)
    );

    intc_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .pend_i(ir_vec), .lvl_i(lvl_vec), .cur_lvl_i(cur_lvl_o),
        .win_o(win), .win_idx_o(win_idx)
    );

    intc_core_fsm #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .win_i(win), .win_idx_i(win_idx),
        .ack_i(ack_i), .ret_i(ret_i), .gie_wr_i(gie_wr_i), .gie_i(gie_i),
        .req_o(irq_req_o), .take_o(take), .num_o(irq_num_o), .lvl_o(irq_lvl_o),
        .gie_o(gie_o), .cur_lvl_o(cur_lvl_o), .in_svc_o(in_svc)
    );
endmodule

// File: rtl/prio_intc_checker.sv
module prio_intc_checker
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               ack_i,
    input logic               ret_i,
    input logic               irq_req_o,
    input logic [IDX_W-1:0]   irq_num_o,
    input logic [LVL_W-1:0]   irq_lvl_o,
    input logic               gie_o,
    input logic [LVL_W-1:0]   cur_lvl_o,
    input logic               in_svc,
    input logic [NUM_SRC-1:0] ir_vec
);
    assert_req_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (gie_o && !in_svc));

    assert_take_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_req_o) |=> (!gie_o && in_svc && cur_lvl_o == irq_lvl_o));

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && irq_req_o) |=> ($stable(irq_num_o) && $stable(irq_lvl_o)));

    assert_return_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && in_svc) |=> !in_svc);

    assert_idle_level_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_svc |-> (cur_lvl_o == '0));

    assert_no_soft_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_vec & ~$past(ir_vec) & ~$past(evt_i)) == '0);

    assert_serve_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc |-> !irq_req_o);
endmodule

bind prio_intc prio_intc_checker #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ack_i(ack_i), .ret_i(ret_i),
    .irq_req_o(irq_req_o), .irq_num_o(irq_num_o), .irq_lvl_o(irq_lvl_o),
    .gie_o(gie_o), .cur_lvl_o(cur_lvl_o), .in_svc(in_svc), .ir_vec(ir_vec)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
    localparam int NS = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] evt = '0;
    logic          sw_wr = 1'b0;
    logic [IW-1:0] sw_idx = '0;
    logic [3:0]    sw_wdata = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [3:0]    rdata;
    logic          gie_wr = 1'b0;
    logic          gie_v = 1'b0;
    logic          ack = 1'b0;
    logic          ret = 1'b0;
    logic          req;
    logic [IW-1:0] num;
    logic [2:0]    lvl;
    logic          gie;
    logic [2:0]    cur;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    bit m_ir[NS];
    int m_lvl[NS];
    bit m_gie, m_svc, m_sg;
    int m_cur, m_sl, m_num, m_nlvl;

    always #10 clk = ~clk;

    prio_intc #(.NUM_SRC(NS)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .sw_wr_i(sw_wr), .sw_idx_i(sw_idx),
        .sw_wdata_i(sw_wdata), .sw_rd_idx_i(rd_idx), .sw_rdata_o(rdata),
        .gie_wr_i(gie_wr), .gie_i(gie_v), .ack_i(ack), .ret_i(ret),
        .irq_req_o(req), .irq_num_o(num), .irq_lvl_o(lvl),
        .gie_o(gie), .cur_lvl_o(cur)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int win_idx();
        int w = -1;
        for (int i = 0; i < NS; i++)
            if (m_ir[i] && m_lvl[i] > m_cur && (w < 0 || m_lvl[i] > m_lvl[w])) w = i;
        return w;
    endfunction

    function automatic bit exp_req();
        return !m_svc && m_gie && (win_idx() >= 0);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin m_ir[i] = 0; m_lvl[i] = 0; end
        m_gie = 0; m_svc = 0; m_sg = 0; m_cur = 0; m_sl = 0; m_num = 0; m_nlvl = 0;
    endtask

    task automatic model_update();
        int  w  = win_idx();
        bit  tk = ack && exp_req();
        bit  rt = ret && m_svc;
        for (int i = 0; i < NS; i++) begin
            if (evt[i]) m_ir[i] = 1;
            else if ((tk && i == w) || (sw_wr && int'(sw_idx) == i && !sw_wdata[3])) m_ir[i] = 0;
        end
        if (tk) begin
            m_sg = m_gie; m_sl = m_cur; m_gie = 0; m_cur = m_lvl[w];
            m_num = w; m_nlvl = m_lvl[w]; m_svc = 1;
        end else if (rt) begin
            m_gie = m_sg; m_cur = m_sl; m_svc = 0;
        end else if (gie_wr) m_gie = gie_v;
        if (sw_wr) m_lvl[sw_idx] = int'(sw_wdata[2:0]);
    endtask

    task automatic compare_all();
        check("R3 req", int'(req), int'(exp_req()));
        check("R4 num", int'(num), m_num);
        check("R6 lvl", int'(lvl), m_nlvl);
        check("R10 gie", int'(gie), int'(m_gie));
        check("R7 cur", int'(cur), m_cur);
        check("R9 rdata", int'(rdata), {m_ir[rd_idx], 3'(m_lvl[rd_idx])});
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
        evt = '0; sw_wr = 0; gie_wr = 0; ack = 0; ret = 0;
    endtask

    task automatic sw_write(input int idx, input bit keep, input int lv);
        sw_wr = 1; sw_idx = IW'(idx); sw_wdata = {keep, 3'(lv)};
        tick();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 req", int'(req), 0);
        check("R1 gie", int'(gie), 0);
        check("R1 cur", int'(cur), 0);
        check("R1 num", int'(num), 0);
        check("R1 rdata", int'(rdata), 0);
        rst_n = 1;
        tick();

        sw_write(0, 0, 0);
        sw_write(1, 0, 3);
        sw_write(2, 0, 5);
        sw_write(3, 0, 5);
        // R2: events with global enable off still set pending flags
        evt = 8'h0F; tick();
        rd_idx = 0; tick();
        check("R2 masked set", int'(rdata[3]), 1);
        check("R3 no req when gie=0", int'(req), 0);
        // R9: keep-bit write on a clear flag must not set it
        sw_write(5, 1, 6);
        rd_idx = 5; tick();
        check("R9 no set", int'(rdata), 4'b0110);
        gie_wr = 1; gie_v = 1; tick();
        check("R3 req", int'(req), 1);
        ack = 1; tick();
        check("R4 tie lowest idx", int'(num), 2);
        check("R5 level", int'(cur), 5);
        // R8: event for same source during service
        evt = 8'h04; tick();
        check("R11 no req in service", int'(req), 0);
        gie_wr = 1; gie_v = 1; tick();
        check("R11 gie set in service", int'(req), 0);
        ret = 1; tick();
        check("R8 re-request", int'(req), 1);
        ack = 1; tick();
        check("R8 re-entry", int'(num), 2);
        ret = 1; tick();
        ret = 1; tick();  // R7 return while idle ignored
        // R9: clearing write with event in the same cycle
        sw_wr = 1; sw_idx = 1; sw_wdata = 4'b0011; evt = 8'h02; tick();
        rd_idx = 1; tick();
        check("R9 event beats clear", int'(rdata[3]), 1);

        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < NS; i++) evt[i] = ($urandom % 8) == 0;
            sw_wr    = ($urandom % 8) == 0;
            sw_idx   = IW'($urandom);
            sw_wdata = 4'($urandom);
            rd_idx   = IW'($urandom);
            gie_wr   = ($urandom % 10) == 0;
            gie_v    = ($urandom % 10) < 7;
            ack      = ($urandom % 2) == 0;
            ret      = ($urandom % 6) == 0;
            tick();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule